// File: doc/BRIEF.md
# Three-Bit Function ALU with Set-Less-Than

This block is a purely combinational arithmetic and logic unit of configurable width, 32 bits by default. It takes two operands and a 3-bit function code and produces a result word and the carry out of its single adder. The top bit of the function code inverts the second operand and also feeds the adder's carry in. Because of this, subtraction, set-less-than, AND with the complement and OR with the complement all use the same inverted operand path. The two low bits of the code choose among the bitwise AND, the bitwise OR, the adder sum and the zero-extended sign bit of the sum.

It is meant to sit inside a processor datapath between the register read stage and the write-back stage. It holds no state: the result follows the inputs within the same cycle.

Top module: `alu_sel3`

## Requirements
- R1: Function code 000 drives the result with the bitwise AND of the two operands.
- R2: Function code 001 drives the result with the bitwise OR of the two operands.
- R3: Function code 010 drives the result with the sum of the operands modulo 2^WIDTH.
- R4: Function code 100 drives the result with the first operand ANDed with the complement of the second.
- R5: Function code 101 drives the result with the first operand ORed with the complement of the second.
- R6: Function code 110 drives the result with the first operand minus the second, modulo 2^WIDTH.
- R7: Function code 111 drives bit 0 of the result with the most significant bit of (first operand minus second) and drives every other bit with zero. For example, operands 25 and 32 give 0x00000001.
- R8: Function code 011 drives the result with all zeros.
- R9: For every code, carry_out is the carry out of adding the first operand, the second operand inverted when code bit 2 is set, and code bit 2 itself. For the subtracting codes, this makes carry_out equal to 1 exactly when the first operand is greater than or equal to the second, compared as unsigned values.
- R10: The block has no storage, so the result and carry_out reflect the current inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| func | input | 3 | Function code |
| result | output | WIDTH | Selected result |
| carry_out | output | 1 | Carry out of the shared adder |

## Verification
The bench pairs every function code with the operands zero, all ones and the most negative value, with the worked operand pair 25 and 32, and with random values. A design that failed to route code bit 2 into the carry in would return results off by one for subtraction and set-less-than, and would report the wrong carry when the operands are equal. A design that sign-extended the set-less-than bit would return all ones instead of one. A design that let code 011 fall through to the sum would return a non-zero value for that code.

// File: rtl/alu_sel3.sv
module alu_sel3 #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [2:0]       func,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  logic             inv_sel;
  logic [WIDTH-1:0] b_path;
  logic [WIDTH-1:0] sum;

  assign inv_sel = func[2];
  assign b_path  = inv_sel ? ~op_b : op_b;
  assign {carry_out, sum} = {1'b0, op_a} + {1'b0, b_path} + {{WIDTH{1'b0}}, inv_sel};

  always_comb begin
    if (func == 3'b011) begin
      result = '0;
    end else begin
      unique case (func[1:0])
        2'b00:   result = op_a & b_path;
        2'b01:   result = op_a | b_path;
        2'b10:   result = sum;
        default: result = {{(WIDTH-1){1'b0}}, sum[WIDTH-1]};
      endcase
    end
  end
endmodule

// File: rtl/alu_sel3_chk.sv
module alu_sel3_chk #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [2:0]       func,
  input logic [WIDTH-1:0] result,
  input logic             carry_out
);
  logic [WIDTH-1:0] back_add;
  logic [WIDTH-1:0] back_sub;
  assign back_add = result + op_b;
  assign back_sub = result - op_b;

  always_comb begin
    if (func == 3'b000) assert_and_inside_a_R1: assert ((result & ~op_a) == '0);
    if (func == 3'b001) assert_or_covers_a_R2: assert ((result & op_a) == op_a);
    if (func == 3'b010) assert_sum_inverts_R3: assert (back_sub == op_a);
    if (func == 3'b100) assert_andn_clear_b_R4: assert ((result & op_b) == '0);
    if (func == 3'b110) assert_diff_inverts_R6: assert (back_add == op_a);
    if (func == 3'b110) assert_borrow_R9: assert (carry_out == (op_a >= op_b));
    if (func == 3'b111) assert_slt_upper_zero_R7: assert (result[WIDTH-1:1] == '0);
    if (func == 3'b011) assert_unused_zero_R8: assert (result == '0);
  end
endmodule

bind alu_sel3 alu_sel3_chk #(.WIDTH(WIDTH)) chk_i (.*);

// File: tb/alu_sel3_tb_top.sv
module alu_sel3_tb_top;
  localparam int W = 32;
  localparam time CLK_PERIOD = 10ns;

  typedef struct {
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [2:0]   f;
    logic [W-1:0] exp_y;
    logic         exp_c;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [2:0]   func = 3'b000;
  logic [W-1:0] result;
  logic         carry_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_sel3 #(.WIDTH(W)) dut_i (
    .op_a(op_a), .op_b(op_b), .func(func), .result(result), .carry_out(carry_out)
  );

  function automatic string req_of(input logic [2:0] f);
    case (f)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b100: return "R4";
      3'b101: return "R5";
      3'b110: return "R6";
      3'b111: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic item_t model(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] f);
    item_t it;
    logic [W:0] wide;
    logic [W-1:0] diff;
    it.a = a; it.b = b; it.f = f;
    diff = a - b;
    wide = {1'b0, a} + {1'b0, b};
    case (f)
      3'b000: it.exp_y = a & b;
      3'b001: it.exp_y = a | b;
      3'b010: it.exp_y = wide[W-1:0];
      3'b100: it.exp_y = a & ~b;
      3'b101: it.exp_y = a | ~b;
      3'b110: it.exp_y = diff;
      3'b111: it.exp_y = (diff >> (W-1));
      default: it.exp_y = '0;
    endcase
    it.exp_c = f[2] ? (a >= b) : wide[W];
    return it;
  endfunction

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] f);
    @(posedge clk);
    #1;
    op_a = a; op_b = b; func = f;
    sb.push_back(model(a, b, f));
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        if (result !== it.exp_y) begin
          fails++;
          $display("FAIL %s f=%b a=%h b=%h result %h expected %h", req_of(it.f), it.f, it.a, it.b, result, it.exp_y);
        end
        checks++;
        if (carry_out !== it.exp_c) begin
          fails++;
          $display("FAIL R9 f=%b a=%h b=%h carry %b expected %b", it.f, it.a, it.b, carry_out, it.exp_c);
        end
      end
    end
  end

  initial begin : driver
    logic [W-1:0] edges [4];
    edges[0] = '0;
    edges[1] = '1;
    edges[2] = {1'b1, {(W-1){1'b0}}};
    edges[3] = 32'd7;
    repeat (2) @(posedge clk);
    // Reset state with no stimulus applied: code 000 on zeros gives zero (R1, R10)
    #1;
    checks++;
    if (result !== '0 || carry_out !== 1'b0) begin
      fails++;
      $display("FAIL R10 idle result %h expected 0, carry %b expected 0", result, carry_out);
    end
    rst = 1'b0;
    // Worked set-less-than case (R7)
    drive(32'd25, 32'd32, 3'b111);
    // Equal operands subtract: carry set, difference zero (R6, R9)
    drive(32'd77, 32'd77, 3'b110);
    drive(32'd77, 32'd77, 3'b111);
    for (int f = 0; f < 8; f++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          drive(edges[i], edges[j], 3'(f));
    for (int n = 0; n < 400; n++)
      drive($urandom, $urandom, 3'($urandom));
    repeat (3) @(posedge clk);
    done = 1'b1;
  end

  initial begin : finisher
    fork
      wait (done);
      begin
        #(CLK_PERIOD * 5000);
        checks++;
        fails++;
        $display("FAIL watchdog expired with %0d items pending", sb.size());
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule